// File: doc/BRIEF.md
# Host-to-DSP Word Mailbox

This block lets an 8-bit host and a 16-bit signal processor pass words to each other through a pair of one-deep latches, one for each direction. The host moves bytes and assembles a word by writing the low byte first and then the high byte. The high-byte write commits the word and raises a flag that tells the processor a word is waiting. When the processor sends a word back, a second flag is raised. The host reads the outbound word low byte first, and its high-byte read lowers that flag.

On the processor side, the block decodes an I/O port space from a 3-bit port number and separate read and write strobes. The memory-enable input must be low for a port access to count. A poll-select register chooses which status bit drives a single registered poll line, so the processor can spin on one branch-test input. One port also holds a frame-select bit, and writing that port points the poll line at vertical sync.

The design uses one clock. Each host or processor access is a strobe that lasts exactly one clock.

Top module: `mbx_bridge`

## Requirements
- R1: After reset, both flags, the poll select, the poll line, frame_sel and all latches are zero.
- R2: A host write to address 0 only stages a low byte. It does not change the inbound word the processor sees and does not set the inbound flag. A host write to address 1 loads the inbound word {high byte, staged low byte} and sets the inbound flag.
- R3: A processor read of port 6 (d_den=1, d_mem=0) returns the inbound word and clears the inbound flag. If a host high-byte write happens in the same cycle, the flag stays set.
- R4: A processor write of port 6 (d_we=1, d_mem=0) loads the outbound word and sets the outbound flag. Any strobe made while d_mem=1 has no effect on any latch or flag.
- R5: A host read of address 0 returns outbound bits 7:0 and leaves the outbound flag alone. A host read of address 1 returns bits 15:8 and clears the outbound flag. A processor port-6 write in the same cycle keeps the flag set.
- R6: A host read of address 2 returns a status byte: bit 0 is the inbound flag, bit 1 is the outbound flag, and the other bits are zero.
- R7: A processor write of port 4 loads the poll select from data bits 1:0. The codes are: 0 selects the inbound flag, 1 selects the outbound flag, 2 selects vsync, and 3 forces the poll line to 0. The poll line is registered, so it shows the selected source as it was one clock earlier.
- R8: A processor write of port 5 loads frame_sel from data bit 0 and sets the poll select to 2 (vsync).
- R9: A host write to address 3 loads an 8-bit control byte. A processor read of port 7 returns it zero-extended.
- R10: A host high-byte write while the inbound flag is still set replaces the inbound word and leaves the flag set.
- R11: d_rdata is zero unless the processor is reading port 6 or port 7 with d_mem=0. h_rdata is zero unless the host is reading address 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_cs | input | 1 | Host access strobe, one cycle per byte |
| h_wr | input | 1 | Host direction: 1 write, 0 read |
| h_addr | input | 2 | Host byte address: 0 low, 1 high, 2 status, 3 control |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte (combinational) |
| d_mem | input | 1 | Processor memory enable; port accesses need it low |
| d_den | input | 1 | Processor port read strobe |
| d_we | input | 1 | Processor port write strobe |
| d_addr | input | 3 | Processor port number |
| d_wdata | input | 16 | Processor write word |
| d_rdata | output | 16 | Processor read word (combinational) |
| vsync | input | 1 | Vertical sync status input |
| frame_sel | output | 1 | Frame buffer select bit |
| poll | output | 1 | Registered, active-high poll line |

## Verification
A flag stuck in the wrong state shows up in the host status byte on the next access. After one more clock it also shows up on the poll line, whenever that flag is the selected source. A bad byte ordering or a latch that was loaded too early shows up as a wrong word at the very next read of the other side, so each table step reads back what the step before it should have changed. The tests on poll timing sample the line in the cycle right after a select write and again in the cycle after that. This exposes a poll path that has lost its register or has gained an extra one.

// File: rtl/mbx_bridge.sv
module mbx_bridge #(
  parameter int HB  = 8,
  parameter int PAW = 3,
  parameter logic [PAW-1:0] P_DATA  = 3'd6,
  parameter logic [PAW-1:0] P_CTRL  = 3'd7,
  parameter logic [PAW-1:0] P_PSEL  = 3'd4,
  parameter logic [PAW-1:0] P_FRAME = 3'd5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            h_cs,
  input  logic            h_wr,
  input  logic [1:0]      h_addr,
  input  logic [HB-1:0]   h_wdata,
  output logic [HB-1:0]   h_rdata,
  input  logic            d_mem,
  input  logic            d_den,
  input  logic            d_we,
  input  logic [PAW-1:0]  d_addr,
  input  logic [2*HB-1:0] d_wdata,
  output logic [2*HB-1:0] d_rdata,
  input  logic            vsync,
  output logic            frame_sel,
  output logic            poll
);
  localparam int WB = 2 * HB;

  logic [HB-1:0] lo_stage_q, ctrl_q;
  logic [WB-1:0] in_word_q, out_word_q;
  logic          hav_q, dav_q;
  logic [1:0]    psel_q;
  logic          poll_src;

  wire h_wlo  = h_cs &  h_wr & (h_addr == 2'd0);
  wire h_whi  = h_cs &  h_wr & (h_addr == 2'd1);
  wire h_wctl = h_cs &  h_wr & (h_addr == 2'd3);
  wire h_rlo  = h_cs & ~h_wr & (h_addr == 2'd0);
  wire h_rhi  = h_cs & ~h_wr & (h_addr == 2'd1);
  wire h_rst  = h_cs & ~h_wr & (h_addr == 2'd2);

  wire d_rd   = ~d_mem & d_den;
  wire d_wr   = ~d_mem & d_we;
  wire d_rdat = d_rd & (d_addr == P_DATA);
  wire d_rctl = d_rd & (d_addr == P_CTRL);
  wire d_wdat = d_wr & (d_addr == P_DATA);
  wire d_wps  = d_wr & (d_addr == P_PSEL);
  wire d_wfr  = d_wr & (d_addr == P_FRAME);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_stage_q <= '0;
      in_word_q  <= '0;
      ctrl_q     <= '0;
      hav_q      <= 1'b0;
    end else begin
      if (h_wlo)  lo_stage_q <= h_wdata;
      if (h_whi)  in_word_q  <= {h_wdata, lo_stage_q};
      if (h_wctl) ctrl_q     <= h_wdata;
      if (h_whi)       hav_q <= 1'b1;
      else if (d_rdat) hav_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_word_q <= '0;
      dav_q      <= 1'b0;
    end else begin
      if (d_wdat) out_word_q <= d_wdata;
      if (d_wdat)     dav_q <= 1'b1;
      else if (h_rhi) dav_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psel_q    <= 2'd0;
      frame_sel <= 1'b0;
    end else if (d_wfr) begin
      frame_sel <= d_wdata[0];
      psel_q    <= 2'd2;
    end else if (d_wps) begin
      psel_q    <= d_wdata[1:0];
    end
  end

  always_comb begin
    case (psel_q)
      2'd0:    poll_src = hav_q;
      2'd1:    poll_src = dav_q;
      2'd2:    poll_src = vsync;
      default: poll_src = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) poll <= 1'b0;
    else        poll <= poll_src;
  end

  assign h_rdata = h_rlo ? out_word_q[HB-1:0] :
                   h_rhi ? out_word_q[WB-1:HB] :
                   h_rst ? {{(HB-2){1'b0}}, dav_q, hav_q} : '0;

  assign d_rdata = d_rdat ? in_word_q :
                   d_rctl ? {{HB{1'b0}}, ctrl_q} : '0;
endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
  parameter int HB  = 8,
  parameter int PAW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            h_cs,
  input logic            h_wr,
  input logic [1:0]      h_addr,
  input logic [HB-1:0]   h_rdata,
  input logic            d_mem,
  input logic            d_den,
  input logic            d_we,
  input logic [PAW-1:0]  d_addr,
  input logic            poll,
  input logic            hav,
  input logic            dav,
  input logic [1:0]      psel,
  input logic [2*HB-1:0] out_word
);
  wire hi_wr  = h_cs & h_wr & (h_addr == 2'd1);
  wire hi_rd  = h_cs & ~h_wr & (h_addr == 2'd1);
  wire dsp_rd = ~d_mem & d_den & (d_addr == 3'd6);
  wire dsp_wr = ~d_mem & d_we & (d_addr == 3'd6);

  assert_inbound_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> hav);
  assert_inbound_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_rd && !hi_wr) |=> !hav);
  assert_outbound_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_wr |=> dav);
  assert_mem_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    d_mem |=> $stable(out_word));
  assert_outbound_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rd && !dsp_wr) |=> !dav);
  assert_status_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cs && !h_wr && h_addr == 2'd2) |-> (h_rdata[HB-1:2] == '0));
  assert_poll_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (psel == 2'd3) |=> !poll);
  assert_poll_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (psel == 2'd0) |=> (poll == $past(hav)));
endmodule

bind mbx_bridge mbx_bridge_chk #(.HB(HB), .PAW(PAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_cs(h_cs), .h_wr(h_wr), .h_addr(h_addr),
  .h_rdata(h_rdata), .d_mem(d_mem), .d_den(d_den), .d_we(d_we),
  .d_addr(d_addr), .poll(poll), .hav(hav_q), .dav(dav_q), .psel(psel_q),
  .out_word(out_word_q)
);

// File: tb/sim_mbx_bridge.sv
module sim_mbx_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_cs = 0, h_wr = 0;
  logic [1:0] h_addr = 0;
  logic [7:0] h_wdata = 0;
  logic [7:0] h_rdata;
  logic d_mem = 0, d_den = 0, d_we = 0;
  logic [2:0] d_addr = 0;
  logic [15:0] d_wdata = 0;
  logic [15:0] d_rdata;
  logic vsync = 0;
  logic frame_sel, poll;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mbx_bridge u0 (.*);

  // kind: 0 host write, 1 host read, 2 dsp write, 3 dsp read
  localparam logic [36:0] VEC [17] = '{
    {2'd1, 3'd2, 16'h0000, 16'h0000},  // R1 status zero
    {2'd0, 3'd0, 16'h0034, 16'h0000},  // R2 low byte staged
    {2'd1, 3'd2, 16'h0000, 16'h0000},  // R2 no flag from low byte
    {2'd3, 3'd6, 16'h0000, 16'h0000},  // R2 inbound word untouched
    {2'd0, 3'd1, 16'h0012, 16'h0000},  // R2 high byte commits
    {2'd1, 3'd2, 16'h0000, 16'h0001},  // R6 inbound flag bit 0
    {2'd3, 3'd6, 16'h0000, 16'h1234},  // R3 word assembled
    {2'd1, 3'd2, 16'h0000, 16'h0000},  // R3 flag cleared
    {2'd2, 3'd6, 16'hBEEF, 16'h0000},  // R4 outbound write
    {2'd1, 3'd2, 16'h0000, 16'h0002},  // R4 outbound flag bit 1
    {2'd1, 3'd0, 16'h0000, 16'h00EF},  // R5 low byte
    {2'd1, 3'd2, 16'h0000, 16'h0002},  // R5 low read keeps flag
    {2'd1, 3'd1, 16'h0000, 16'h00BE},  // R5 high byte
    {2'd1, 3'd2, 16'h0000, 16'h0000},  // R5 flag cleared
    {2'd0, 3'd3, 16'h005A, 16'h0000},  // R9 control byte
    {2'd3, 3'd7, 16'h0000, 16'h005A},  // R9 control readback
    {2'd3, 3'd3, 16'h0000, 16'h0000}   // R11 unused port reads zero
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    h_cs = 0; h_wr = 0; d_den = 0; d_we = 0; d_mem = 0;
  endtask

  task automatic op(input logic [1:0] kind, input logic [2:0] a,
                    input logic [15:0] dat, input logic [15:0] exp,
                    input string tag, input bit mem = 0);
    @(negedge clk);
    idle();
    d_mem = mem;
    case (kind)
      2'd0: begin h_cs = 1; h_wr = 1; h_addr = a[1:0]; h_wdata = dat[7:0]; end
      2'd1: begin h_cs = 1; h_wr = 0; h_addr = a[1:0]; end
      2'd2: begin d_we = 1; d_addr = a; d_wdata = dat; end
      default: begin d_den = 1; d_addr = a; end
    endcase
    #1;
    if (kind == 2'd1) chk(h_rdata == exp[7:0], tag, h_rdata, exp[7:0]);
    if (kind == 2'd3) chk(d_rdata == exp, tag, d_rdata, exp);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk(poll == 0, "R1 poll", poll, 0);
    chk(frame_sel == 0, "R1 frame_sel", frame_sel, 0);
    chk(d_rdata == 0, "R11 idle d_rdata", d_rdata, 0);
    chk(h_rdata == 0, "R11 idle h_rdata", h_rdata, 0);

    foreach (VEC[i])
      op(VEC[i][36:35], VEC[i][34:32], VEC[i][31:16], VEC[i][15:0], $sformatf("vector %0d", i));

    // R10 overwrite while inbound flag is set
    op(0, 0, 16'h11, 0, "R10");
    op(0, 1, 16'h22, 0, "R10");
    op(0, 0, 16'h33, 0, "R10");
    op(0, 1, 16'h44, 0, "R10");
    op(1, 2, 0, 16'h1, "R10 flag still set");
    op(3, 6, 0, 16'h4433, "R10 newer word");

    // R3 set wins over clear in same cycle
    op(0, 0, 16'h66, 0, "R3");
    @(negedge clk);
    h_cs = 1; h_wr = 1; h_addr = 1; h_wdata = 8'h77; d_den = 1; d_addr = 6;
    #1 chk(d_rdata == 16'h4433, "R3 same-cycle read old word", d_rdata, 16'h4433);
    @(negedge clk); idle();
    op(1, 2, 0, 16'h1, "R3 set wins");
    op(3, 6, 0, 16'h7766, "R3 word after collision");

    // R4 strobes with memory enable high are ignored
    op(2, 6, 16'hAAAA, 0, "R4", 1);
    op(1, 2, 0, 16'h0, "R4 mem-high write ignored");
    op(3, 6, 0, 16'h0, "R11 mem-high read gives zero", 1);
    op(1, 0, 0, 16'hEF, "R4 outbound word kept");

    // R5 set wins over host high read
    @(negedge clk);
    h_cs = 1; h_wr = 0; h_addr = 1; d_we = 1; d_addr = 6; d_wdata = 16'hC0DE;
    @(negedge clk); idle();
    op(1, 2, 0, 16'h2, "R5 set wins");
    op(1, 1, 0, 16'hC0, "R5 new high byte");

    // R7 poll select and register timing
    op(2, 4, 16'h1, 0, "R7");
    @(posedge clk); #1;
    chk(poll == 0, "R7 sel1 dav low", poll, 0);
    op(2, 6, 16'h0101, 0, "R7");
    @(posedge clk); #1;
    chk(poll == 1, "R7 sel1 dav high", poll, 1);
    vsync = 1;
    op(2, 4, 16'h2, 0, "R7");
    @(posedge clk); #1;
    chk(poll == 1, "R7 sel2 vsync high", poll, 1);
    op(2, 4, 16'h3, 0, "R7");
    chk(poll == 1, "R7 poll one clock late", poll, 1);
    @(posedge clk); #1;
    chk(poll == 0, "R7 sel3 forced zero", poll, 0);

    // R8 frame select also points poll at vsync
    op(2, 5, 16'h1, 0, "R8");
    chk(frame_sel == 1, "R8 frame_sel set", frame_sel, 1);
    @(posedge clk); #1;
    chk(poll == 1, "R8 poll follows vsync", poll, 1);
    vsync = 0;
    @(posedge clk); #1;
    chk(poll == 0, "R8 poll follows vsync low", poll, 0);
    op(2, 5, 16'h0, 0, "R8");
    chk(frame_sel == 0, "R8 frame_sel clear", frame_sel, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule